// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Queue

This block accepts 32-bit words from a host, holds them in a first-in first-out queue and sends each one as a logical serial bit stream in the avionics word format. It sends the least significant bit first. A fixed silent gap follows every word. The host writes a word by raising `wr_en` for one cycle. Transmission starts by itself whenever the queue holds a word. The host does not request it. Each bit is held for a whole bit period. A one-cycle `*_bit_start` pulse marks the first clock of every bit, and `*_valid` is high for the whole word.

Three configuration inputs are sampled when a word leaves the queue, so they apply to the whole of that word. `rate_slow` picks the bit period: 10 clocks or 80 clocks. `par_en` chooses whether the top bit is sent as written or replaced by a parity bit. `par_odd` picks odd or even parity. `self_test` sends the stream to the loopback outputs instead of the line outputs, so that a receiver can be exercised with no line traffic. The status outputs show whether the queue is empty, at least half full, or full.

The controller has three states. In IDLE it waits for the queue to be non-empty. On the transition IDLE→SEND it pops a word, shapes bit 32 and restarts the bit timer. SEND shifts the 32 bits out. On the transition SEND→GAP, after the last bit period, the outputs go quiet. GAP counts four bit periods. The transition GAP→IDLE ends the word.

Top module: `a429_tx_top`

## Requirements
- R1: The word is sent LSB first: wr_data[0] is the first bit and wr_data[31] (after shaping) is the 32nd. `*_bit_start` pulses on the first cycle of each bit, and `*_valid` is high from the first bit to the end of the 32nd.
- R2: The bit period, measured between consecutive bit-start pulses, is 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. The value is sampled when the word is popped.
- R3: With `par_en`=0, bit 32 is sent unchanged as wr_data[31].
- R4: With `par_en`=1, bit 32 is replaced by parity over bits 1..31. With `par_odd`=1 the 32 sent bits hold an odd number of ones. With `par_odd`=0 they hold an even number.
- R5: Between two consecutive words, `*_valid` stays low for at least 4 bit periods.
- R6: `fifo_empty` is 1 when the queue holds no word and 0 otherwise. It is 1 after reset.
- R7: `fifo_half` is 1 when the queue holds 16 or more words and 0 when it holds 15 or fewer.
- R8: `fifo_full` is 1 when the queue holds 32 words. A write while full is dropped, and the words already queued are unaffected.
- R9: Transmission starts with no request whenever the queue is non-empty, and words are sent in the order written.
- R10: With `self_test`=1 the stream appears on the `lb_*` outputs and the `line_*` outputs stay low. With `self_test`=0 the roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Word to queue |
| rate_slow | input | 1 | 0: bit period 10 clocks, 1: 80 clocks |
| par_en | input | 1 | 1: bit 32 replaced by parity |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| self_test | input | 1 | 1: route stream to loopback outputs |
| line_bit | output | 1 | Serial data toward the line |
| line_valid | output | 1 | Word in progress on the line outputs |
| line_bit_start | output | 1 | First cycle of each line bit |
| lb_bit | output | 1 | Serial data toward the internal receiver |
| lb_valid | output | 1 | Word in progress on the loopback outputs |
| lb_bit_start | output | 1 | First cycle of each loopback bit |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_half | output | 1 | Queue holds 16 or more words |
| fifo_full | output | 1 | Queue holds 32 words |

## Verification
The assertions assume that `self_test` changes only while no word is in progress. If it switched mid-word, a stream could begin on one pair of outputs without a bit-start pulse. They also assume that reset is held for at least one clock edge. The bench changes `self_test` and the rate and parity inputs only after the previous word has fully left. It holds reset low for several clocks. All its stimulus is driven on the falling clock edge.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    // Shape the top bit: pass through, or parity over the lower 31 bits
    function automatic logic [31:0] shape_word(input logic [31:0] w,
                                               input logic        pen,
                                               input logic        podd);
        logic p;
        p = podd ? ~(^w[30:0]) : (^w[30:0]);
        return pen ? {p, w[30:0]} : w;
    endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             half,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int HALF_LVL = DEPTH / 2;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      level;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
    assign empty     = (level == '0);
    assign full      = (level == (AW+1)'(DEPTH));
    assign half      = (level >= (AW+1)'(HALF_LVL));

endmodule

// File: rtl/a429_tx_baud.sv
module a429_tx_baud #(
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow,
    output logic tick,
    output logic bit_first
);
    localparam int CW = $clog2(SLOW_DIV);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick      = (cnt == lim) && !restart;
    assign bit_first = (cnt == '0);

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
    import a429_tx_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int GAP_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_empty,
    input  logic [WORD_BITS-1:0] q_data,
    input  logic                 rate_slow,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 tick,
    input  logic                 bit_first,
    output logic                 pop,
    output logic                 baud_restart,
    output logic                 slow_q,
    output logic                 ser_bit,
    output logic                 ser_valid,
    output logic                 ser_start
);
    localparam int IW = $clog2(WORD_BITS);
    localparam int GW = $clog2(GAP_BITS + 1);

    tx_state_e            state, state_nx;
    logic [WORD_BITS-1:0] word_q;
    logic [IW-1:0]        idx;
    logic [GW-1:0]        gap_cnt;
    logic                 last_bit;
    logic                 last_gap;

    assign last_bit = (idx == IW'(WORD_BITS - 1));
    assign last_gap = (gap_cnt == GW'(GAP_BITS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!q_empty)           state_nx = ST_SEND;
            ST_SEND: if (tick && last_bit)   state_nx = ST_GAP;
            ST_GAP:  if (tick && last_gap)   state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            idx     <= '0;
            gap_cnt <= '0;
            slow_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!q_empty) begin
                        word_q  <= shape_word(q_data, par_en, par_odd);
                        slow_q  <= rate_slow;
                        idx     <= '0;
                        gap_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick && !last_bit) begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pop          = 1'b0;
        baud_restart = 1'b0;
        ser_valid    = 1'b0;
        ser_start    = 1'b0;
        ser_bit      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                pop          = !q_empty;
                baud_restart = !q_empty;
            end
            ST_SEND: begin
                ser_valid = 1'b1;
                ser_start = bit_first;
                ser_bit   = word_q[idx];
            end
            ST_GAP:  ;
            default: ;
        endcase
    end

endmodule

// File: rtl/a429_tx_top.sv
module a429_tx_top #(
    parameter int WORD_BITS = 32,
    parameter int DEPTH     = 32,
    parameter int FAST_DIV  = 10,
    parameter int SLOW_DIV  = 80,
    parameter int GAP_BITS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rate_slow,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        self_test,
    output logic        line_bit,
    output logic        line_valid,
    output logic        line_bit_start,
    output logic        lb_bit,
    output logic        lb_valid,
    output logic        lb_bit_start,
    output logic        fifo_empty,
    output logic        fifo_half,
    output logic        fifo_full
);
    logic [WORD_BITS-1:0] head;
    logic pop, restart, slow_q, tick, bit_first;
    logic s_bit, s_valid, s_start;

    a429_tx_fifo #(.WIDTH(WORD_BITS), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head),
        .empty     (fifo_empty),
        .half      (fifo_half),
        .full      (fifo_full)
    );

    a429_tx_baud #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .slow      (slow_q),
        .tick      (tick),
        .bit_first (bit_first)
    );

    a429_tx_ser #(.WORD_BITS(WORD_BITS), .GAP_BITS(GAP_BITS)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_empty      (fifo_empty),
        .q_data       (head),
        .rate_slow    (rate_slow),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .tick         (tick),
        .bit_first    (bit_first),
        .pop          (pop),
        .baud_restart (restart),
        .slow_q       (slow_q),
        .ser_bit      (s_bit),
        .ser_valid    (s_valid),
        .ser_start    (s_start)
    );

    // Route the stream either to the line or to the internal receiver
    always_comb begin
        line_bit       = self_test ? 1'b0 : s_bit;
        line_valid     = self_test ? 1'b0 : s_valid;
        line_bit_start = self_test ? 1'b0 : s_start;
        lb_bit         = self_test ? s_bit   : 1'b0;
        lb_valid       = self_test ? s_valid : 1'b0;
        lb_bit_start   = self_test ? s_start : 1'b0;
    end

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic line_bit,
    input logic line_valid,
    input logic line_bit_start,
    input logic lb_valid,
    input logic lb_bit_start,
    input logic fifo_empty,
    input logic fifo_half,
    input logic fifo_full
);
    // R1
    word_opens_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> line_bit_start);

    // R1
    bit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid) && !line_bit_start) |-> $stable(line_bit));

    // R10
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_valid && lb_valid));

    // R10
    lb_start_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_bit_start |-> lb_valid);

    // R8
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    // R7
    full_has_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_half);

    // R6
    empty_no_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_half);

endmodule

bind a429_tx_top a429_tx_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_bit       (line_bit),
    .line_valid     (line_valid),
    .line_bit_start (line_bit_start),
    .lb_valid       (lb_valid),
    .lb_bit_start   (lb_bit_start),
    .fifo_empty     (fifo_empty),
    .fifo_half      (fifo_half),
    .fifo_full      (fifo_full)
);

// File: tb/a429_tx_top_tb.sv
module a429_tx_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic rate_slow = 1'b0, par_en = 1'b0, par_odd = 1'b0, self_test = 1'b0;
    logic line_bit, line_valid, line_bit_start, lb_bit, lb_valid, lb_bit_start;
    logic fifo_empty, fifo_half, fifo_full;

    always #4 clk = ~clk;

    a429_tx_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rate_slow(rate_slow), .par_en(par_en), .par_odd(par_odd), .self_test(self_test),
        .line_bit(line_bit), .line_valid(line_valid), .line_bit_start(line_bit_start),
        .lb_bit(lb_bit), .lb_valid(lb_valid), .lb_bit_start(lb_bit_start),
        .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic pe, input logic po);
        int ones;
        logic [31:0] r;
        r = w;
        if (pe) begin
            ones = $countones(w[30:0]);
            r[31] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
        end
        return r;
    endfunction

    // Line monitor
    logic [31:0] l_words [64];
    int l_cnt = 0, l_bits = 0, l_per = 0, l_cyc = 0, l_gap = 0, l_min_gap = 1000000;
    logic [31:0] l_sh = '0;
    always @(negedge clk) begin
        if (line_valid) l_cyc++;
        else if (l_cnt > 0) l_gap++;
        if (line_bit_start) begin
            if (l_bits > 0) l_per = l_cyc - 1;
            else if (l_cnt > 0) begin
                if (l_gap < l_min_gap) l_min_gap = l_gap;
                l_gap = 0;
            end
            l_cyc = 1;
            l_sh[l_bits] = line_bit;
            l_bits++;
            if (l_bits == 32) begin
                l_words[l_cnt % 64] = l_sh;
                l_cnt++;
                l_bits = 0;
            end
        end
    end

    // Loopback monitor
    logic [31:0] b_last = '0;
    int b_cnt = 0, b_bits = 0;
    logic [31:0] b_sh = '0;
    always @(negedge clk) begin
        if (lb_bit_start) begin
            b_sh[b_bits] = lb_bit;
            b_bits++;
            if (b_bits == 32) begin
                b_last = b_sh;
                b_cnt++;
                b_bits = 0;
            end
        end
    end

    task automatic put(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_line(input int target);
        for (int k = 0; k < 60000 && l_cnt < target; k++) @(negedge clk);
    endtask

    task automatic wait_quiet();
        for (int k = 0; k < 2000 && !(fifo_empty && !line_valid && !lb_valid); k++) @(negedge clk);
        repeat (400) @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] w;
        logic        slow;
        logic        pe;
        logic        po;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{w: 32'h8000_0001, slow: 1'b0, pe: 1'b0, po: 1'b0},
        '{w: 32'h0000_0003, slow: 1'b0, pe: 1'b1, po: 1'b1},
        '{w: 32'h0000_0007, slow: 1'b0, pe: 1'b1, po: 1'b1},
        '{w: 32'hFFFF_FFFF, slow: 1'b0, pe: 1'b1, po: 1'b0},
        '{w: 32'h7FFF_FFFE, slow: 1'b0, pe: 1'b1, po: 1'b0},
        '{w: 32'hA5C3_1E69, slow: 1'b1, pe: 1'b0, po: 1'b1},
        '{w: 32'h1234_5678, slow: 1'b1, pe: 1'b1, po: 1'b1}
    };

    initial begin
        repeat (1000000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base_cnt;
        int nb;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 R8 reset state
        check(fifo_empty == 1'b1, "R6 empty after reset", fifo_empty, 1);
        check(fifo_half == 1'b0, "R7 half after reset", fifo_half, 0);
        check(fifo_full == 1'b0, "R8 full after reset", fifo_full, 0);
        check(line_valid == 1'b0, "R9 idle after reset", line_valid, 0);

        // Vector table: R1 R2 R3 R4
        for (int i = 0; i < 7; i++) begin
            rate_slow = VECS[i].slow;
            par_en    = VECS[i].pe;
            par_odd   = VECS[i].po;
            base_cnt  = l_cnt;
            put(VECS[i].w);
            wait_line(base_cnt + 1);
            check(l_words[base_cnt % 64] == expect_word(VECS[i].w, VECS[i].pe, VECS[i].po),
                  VECS[i].pe ? "R4 R1 parity word" : "R3 R1 data word",
                  l_words[base_cnt % 64], expect_word(VECS[i].w, VECS[i].pe, VECS[i].po));
            check(l_per == (VECS[i].slow ? 80 : 10), "R2 bit period", l_per, VECS[i].slow ? 80 : 10);
            wait_quiet();
        end

        // R5 gap between back-to-back words, R9 order
        rate_slow = 1'b0;
        par_en = 1'b0;
        l_min_gap = 1000000;
        base_cnt = l_cnt;
        put(32'h0000_1111);
        put(32'h0000_2222);
        wait_line(base_cnt + 2);
        check(l_min_gap >= 40, "R5 inter-word gap", l_min_gap, 40);
        check(l_words[(base_cnt + 1) % 64] == 32'h0000_2222, "R9 second word order",
              l_words[(base_cnt + 1) % 64], 32'h0000_2222);
        wait_quiet();

        // R7 R8 burst of 40 writes; first word leaves at once
        base_cnt = l_cnt;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 16) check(fifo_half == 1'b0, "R7 half at 15 words", fifo_half, 0);
            if (i == 17) check(fifo_half == 1'b1, "R7 half at 16 words", fifo_half, 1);
            wr_en = 1'b1;
            wr_data = 32'hC000_0000 + i;
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(fifo_full == 1'b1, "R8 full after burst", fifo_full, 1);
        check(fifo_half == 1'b1, "R7 half when full", fifo_half, 1);
        check(fifo_empty == 1'b0, "R6 not empty", fifo_empty, 0);
        wait_line(base_cnt + 33);
        wait_quiet();
        check(l_cnt == base_cnt + 33, "R8 dropped writes count", l_cnt - base_cnt, 33);
        check(l_words[(base_cnt + 32) % 64] == 32'hC000_0020, "R8 last kept word",
              l_words[(base_cnt + 32) % 64], 32'hC000_0020);
        check(l_words[(base_cnt + 17) % 64] == 32'hC000_0011, "R9 burst order",
              l_words[(base_cnt + 17) % 64], 32'hC000_0011);
        check(fifo_empty == 1'b1, "R6 empty after drain", fifo_empty, 1);

        // R10 self test
        self_test = 1'b1;
        base_cnt = l_cnt;
        nb = b_cnt;
        put(32'h0F0F_3C3C);
        for (int k = 0; k < 2000 && b_cnt == nb; k++) @(negedge clk);
        check(b_cnt == nb + 1, "R10 loopback word count", b_cnt - nb, 1);
        check(b_last == 32'h0F0F_3C3C, "R10 loopback data", b_last, 32'h0F0F_3C3C);
        check(l_cnt == base_cnt && l_bits == 0, "R10 line silent", l_cnt - base_cnt, 0);
        wait_quiet();
        self_test = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule